// File: doc/BRIEF.md
# Retriggerable Resettable One-Shot Pulse Timer

This block is a clocked monostable. A rising edge on one trigger input, or a falling edge on the other, starts a high pulse whose length is a programmed number of system clock cycles. A down-counter sets that length, so no resistor or capacitor is needed. The block drives the pulse and its complement. An active-low clear input ends a running pulse and keeps new ones from starting. A two-channel part is two instances.

All asynchronous inputs pass through a two-flop synchroniser before edge detection. The delay from an input change to the output change is therefore a constant three clock edges, whatever the programmed length. A mode input selects between two behaviours. In retriggerable mode every accepted edge restarts a full period. In the other mode, edges that arrive during a pulse are dropped. The period value and the mode input are taken as quasi-static settings and are sampled directly.

Top module: `retrig_oneshot`

## Requirements
- R1: A rising edge on `trig_rise` starts a pulse. `pulse` goes high on the third rising clock edge after the input change, counting the first edge that samples the new level as edge one.
- R2: A falling edge on `trig_fall_n` starts a pulse with the same three-edge latency as R1.
- R3: A pulse lasts exactly `period` clock cycles. A `period` value of 0 gives a one-cycle pulse.
- R4: With `retrig_en` = 1, an accepted edge during a pulse reloads the count. The pulse then stays high for `period` cycles counted from the reload edge.
- R5: With `retrig_en` = 0, trigger edges seen while `pulse` is high have no effect. The pulse ends `period` cycles after the edge that started it.
- R6: When `clr_n` goes low, `pulse` goes low on the third clock edge after the change. This latency does not depend on `period`.
- R7: While the synchronised `clr_n` is low, no pulse can start. Trigger levels that are already active when clear is released do not start a pulse. After `rst_n`, `pulse` = 0 and `pulse_n` = 1.
- R8: When edges on both trigger inputs qualify in the same cycle, the block produces one pulse of `period` cycles.
- R9: `pulse_n` is always the inverse of `pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Active-low pulse clear and start inhibit (asynchronous source) |
| trig_rise | input | 1 | Trigger input that fires on its rising edge |
| trig_fall_n | input | 1 | Trigger input that fires on its falling edge |
| retrig_en | input | 1 | 1 = retriggerable, 0 = edges ignored while the pulse is high |
| period | input | CNT_W | Pulse length in clock cycles (0 acts as 1) |
| pulse | output | 1 | True one-shot output |
| pulse_n | output | 1 | Complementary one-shot output |

## Verification
Two functions can land in the same cycle. One is the two trigger inputs qualifying together. The other is a reload landing on an already running count. The bench raises `trig_rise` and lowers `trig_fall_n` in the same drive step and expects exactly one pulse of `period` cycles. It then spaces the two edges one cycle apart in retriggerable mode and expects the width to grow by exactly that one cycle. A scoreboard queue holds the expected start cycle and width of each pulse. Any pulse that appears without a queued entry counts as a mismatch, which covers the clear and ignored-edge cases.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_pol_e;

   // Number of clock edges from an input change to the output change
   function automatic int unsigned path_latency(input int unsigned stages);
      return stages + 1;
   endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] IDLE  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= IDLE;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= IDLE;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
   import oneshot_pkg::*;
#(
   parameter edge_pol_e POL = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic hit
);

   localparam logic IDLE_LVL = (POL == EDGE_FALL);

   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_LVL;
      else        prev <= level;
   end

   if (POL == EDGE_RISE) begin : g_rise
      assign hit = level & ~prev;
   end else begin : g_fall
      assign hit = ~level & prev;
   end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             load,
   input  logic [CNT_W-1:0] length,
   output logic             busy,
   output logic             busy_n,
   output logic [CNT_W-1:0] remain
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] reload;

   always_comb begin
      if (length == '0) reload = '0;
      else              reload = length - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         busy_n <= 1'b1;
         remain <= '0;
      end else if (kill) begin
         busy   <= 1'b0;
         busy_n <= 1'b1;
         remain <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         busy_n <= 1'b0;
         remain <= reload;
      end else if (busy) begin
         if (remain == '0) begin
            busy   <= 1'b0;
            busy_n <= 1'b1;
         end else begin
            remain <= remain - ONE;
         end
      end
   end

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
   import oneshot_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             trig_rise,
   input  logic             trig_fall_n,
   input  logic             retrig_en,
   input  logic [CNT_W-1:0] period,
   output logic             pulse,
   output logic             pulse_n
);

   localparam int unsigned LATENCY = path_latency(SYNC_STAGES);
   localparam int unsigned IN_W    = 3;
   localparam logic [IN_W-1:0] IN_IDLE = 3'b010;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("retrig_oneshot: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("retrig_oneshot: CNT_W must lie in 1..32");
   end
   if (LATENCY != SYNC_STAGES + 1) begin : g_bad_latency
      $error("retrig_oneshot: latency derivation mismatch");
   end

   logic [IN_W-1:0] raw_in;
   logic [IN_W-1:0] synced;
   logic            clr_ok;
   logic            hit_rise;
   logic            hit_fall;
   logic            any_hit;
   logic            start;
   logic            busy;
   logic            busy_n;
   logic [CNT_W-1:0] remain;

   assign raw_in = {clr_n, trig_fall_n, trig_rise};

   oneshot_sync #(
      .W      (IN_W),
      .STAGES (SYNC_STAGES),
      .IDLE   (IN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_in),
      .dout  (synced)
   );

   assign clr_ok = synced[2];

   oneshot_edge #(.POL(EDGE_RISE)) u_edge_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .level (synced[0]),
      .hit   (hit_rise)
   );

   oneshot_edge #(.POL(EDGE_FALL)) u_edge_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .level (synced[1]),
      .hit   (hit_fall)
   );

   // Coincident edges merge into a single trigger
   assign any_hit = hit_rise | hit_fall;
   assign start   = any_hit & clr_ok & (retrig_en | ~busy);

   oneshot_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (~clr_ok),
      .load   (start),
      .length (period),
      .busy   (busy),
      .busy_n (busy_n),
      .remain (remain)
   );

   assign pulse   = busy;
   assign pulse_n = busy_n;

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_ok,
   input logic             start,
   input logic             retrig_en,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] remain,
   input logic             pulse,
   input logic             pulse_n
);

   // R9: the two output registers never agree
   a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_n == !pulse);

   // R6: a synchronised clear drops the pulse on the next edge
   a_r6_clear_kills: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_ok |=> !pulse);

   // R7: no start while clear is active, and no pulse out of nothing
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse && !start) |=> !pulse);

   // R3 / R4: an accepted trigger loads period-1 (0 for period 0)
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (pulse && (($past(period) == '0) ? (remain == '0)
                                                 : (remain + CNT_W'(1) == $past(period)))));

   // R5: in one-shot mode a running count only ever steps down
   a_r5_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
      (!retrig_en && pulse && clr_ok && remain != '0)
         |=> (pulse && remain + CNT_W'(1) == $past(remain)));

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_ok    (clr_ok),
   .start     (start),
   .retrig_en (retrig_en),
   .period    (period),
   .remain    (remain),
   .pulse     (pulse),
   .pulse_n   (pulse_n)
);

// File: tb/retrig_oneshot_test.sv
`timescale 1ns/1ps
module retrig_oneshot_test;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_n = 1'b1;
   logic          trig_rise = 1'b0;
   logic          trig_fall_n = 1'b1;
   logic          retrig_en = 1'b1;
   logic [CW-1:0] period = CW'(4);
   logic          pulse;
   logic          pulse_n;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   bit finished = 1'b0;

   typedef struct {
      int    start;
      int    width;
      string tag;
   } exp_t;
   exp_t sb[$];

   retrig_oneshot #(.CNT_W(CW)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_n       (clr_n),
      .trig_rise   (trig_rise),
      .trig_fall_n (trig_fall_n),
      .retrig_en   (retrig_en),
      .period      (period),
      .pulse       (pulse),
      .pulse_n     (pulse_n)
   );

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   task automatic tick(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic expect_pulse(input int start, input int width, input string tag);
      exp_t e;
      e.start = start;
      e.width = width;
      e.tag   = tag;
      sb.push_back(e);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Monitor: measures each pulse and compares it with the scoreboard
   bit prev_q = 1'b0;
   int rise_at = 0;
   always @(negedge clk) begin
      if (mon_on) begin
         check(pulse_n == ~pulse, "R9 complement", int'(pulse_n), int'(~pulse));
         if (pulse && !prev_q) rise_at = cyc;
         if (!pulse && prev_q) begin
            if (sb.size() == 0) begin
               check(1'b0, "R5/R7 unexpected pulse", cyc - rise_at, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(rise_at == e.start, {e.tag, " start"}, rise_at, e.start);
               check(cyc - rise_at == e.width, {e.tag, " width"}, cyc - rise_at, e.width);
            end
         end
         prev_q = pulse;
      end
   end

   initial begin
      int c;
      int d;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R7: reset state
      check(pulse == 1'b0, "R7 reset pulse", int'(pulse), 0);
      check(pulse_n == 1'b1, "R7 reset pulse_n", int'(pulse_n), 1);
      mon_on = 1'b1;
      tick(4);

      // R1: rising trigger, latency 3, width 5
      period = CW'(5);
      c = cyc; trig_rise = 1'b1; expect_pulse(c + 3, 5, "R1");
      tick(2); trig_rise = 1'b0; tick(12);

      // R2: falling trigger, width 7
      period = CW'(7);
      c = cyc; trig_fall_n = 1'b0; expect_pulse(c + 3, 7, "R2");
      tick(2); trig_fall_n = 1'b1; tick(14);

      // R3: period 0 acts as 1, period 1 gives one cycle
      period = CW'(0);
      c = cyc; trig_rise = 1'b1; expect_pulse(c + 3, 1, "R3 zero");
      tick(2); trig_rise = 1'b0; tick(8);
      period = CW'(1);
      c = cyc; trig_fall_n = 1'b0; expect_pulse(c + 3, 1, "R3 one");
      tick(2); trig_fall_n = 1'b1; tick(8);

      // R4: retrigger after 4 cycles extends by a full period
      retrig_en = 1'b1; period = CW'(10);
      c = cyc; trig_rise = 1'b1;
      tick(2); trig_rise = 1'b0; tick(2);
      d = cyc; trig_rise = 1'b1; expect_pulse(c + 3, d - c + 10, "R4");
      tick(2); trig_rise = 1'b0; tick(20);

      // R5: same stimulus in one-shot mode, second edge dropped
      retrig_en = 1'b0;
      c = cyc; trig_rise = 1'b1; expect_pulse(c + 3, 10, "R5");
      tick(2); trig_rise = 1'b0; tick(2);
      trig_fall_n = 1'b0; tick(2); trig_fall_n = 1'b1;
      trig_rise = 1'b1; tick(2); trig_rise = 1'b0; tick(16);

      // R6: clear ends a long pulse after the fixed latency
      retrig_en = 1'b1; period = CW'(200);
      c = cyc; trig_rise = 1'b1; expect_pulse(c + 3, 6, "R6");
      tick(2); trig_rise = 1'b0; tick(4);
      clr_n = 1'b0;
      tick(5); clr_n = 1'b1; tick(10);

      // R7: edges during clear and levels held across release start nothing
      period = CW'(5);
      clr_n = 1'b0; tick(3);
      trig_rise = 1'b1; tick(4);
      trig_fall_n = 1'b0; tick(4);
      clr_n = 1'b1; tick(10);
      check(pulse == 1'b0, "R7 held levels", int'(pulse), 0);
      trig_rise = 1'b0; trig_fall_n = 1'b1; tick(6);
      check(pulse == 1'b0, "R7 after idle", int'(pulse), 0);

      // R8: both triggers in the same cycle make one pulse
      period = CW'(4);
      c = cyc; trig_rise = 1'b1; trig_fall_n = 1'b0; expect_pulse(c + 3, 4, "R8");
      tick(2); trig_rise = 1'b0; trig_fall_n = 1'b1; tick(10);
      retrig_en = 1'b0;
      c = cyc; trig_rise = 1'b1; trig_fall_n = 1'b0; expect_pulse(c + 3, 4, "R8 one-shot");
      tick(2); trig_rise = 1'b0; trig_fall_n = 1'b1; tick(10);

      // R4: edges one cycle apart on the two inputs
      retrig_en = 1'b1;
      c = cyc; trig_rise = 1'b1; tick(1);
      trig_fall_n = 1'b0; expect_pulse(c + 3, 5, "R4 adjacent");
      tick(2); trig_rise = 1'b0; trig_fall_n = 1'b1; tick(12);

      // R1: all queued pulses observed
      check(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
      check(pulse == 1'b0, "R3 idle at end", int'(pulse), 0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule